// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block collects interrupt events from eight functional units of a line-interface device. It presents them to a local processor through a two-level register scheme on a synchronous byte-wide register bus. Seven of the units each own one to seven event sources, and every source has a latched status bit and an enable bit. A summary register gives one bit per unit, and a unit-enable register gates each summary bit onto a single active-low interrupt line.

Each summary bit for units 7 down to 1 is derived rather than stored. It is the OR of that unit's latched sources that are enabled at source level. Bit 0 is different: it is a directly latched one-second tick that is cleared by reading the summary register. Source status bits latch on the rising edge of their raw event and are cleared by reading the unit's status register. An event that lands in the same cycle as the clearing read is never lost.

Read data is presented combinationally during the cycle in which the read strobe is high. Clear-on-read side effects take place at the clock edge that ends that cycle.

Top module: `irq_hub`

## Requirements
- R1: After reset every enable bit and every status bit at both levels is 0, and `irq_n` is 1.
- R2: The unit-enable register at address 0x04 holds all eight written bits and returns them on read.
- R3: A source status bit goes to 1 one clock after a rising edge of its raw event and stays set while no read clears it. A raw level that stays high does not set it again. Unit u (1..7) source s is raw input bit (u-1)*7+s and is read as bit s of address 0x10+u.
- R4: A read of 0x10+u returns that unit's source status and clears it at the end of the read cycle. A rising edge arriving in that same cycle leaves its bit set.
- R5: The source-enable register of unit u at 0x20+u holds the written bits [n-1:0], where n is the unit's source count (defaults 7,5,2,2,4,3,6 for units 1..7). Bits at and above n read as 0.
- R6: The summary register at 0x05 shows, in bit u (u = 1..7), the OR over unit u's sources of status AND source enable. The bit order is: 7 receive line framer, 6 receive convergence, 5 receive cell processor, 4 receive cell bus, 3 transmit cell bus, 2 transmit cell processor, 1 transmit line framer.
- R7: A one-cycle `tick_pulse` sets summary bit 0. A read of 0x05 clears it, except when a pulse arrives in the same cycle, in which case the bit stays set.
- R8: Writes to 0x05 and to the source status addresses 0x10+u change nothing.
- R9: `irq_n` is 0 exactly when some summary bit and the matching unit-enable bit are both 1.
- R10: `irq_n` returns to 1 in the cycle right after the read that clears the last enabled pending cause.
- R11: `bus_rdata` is 0 whenever `bus_rd` is 0 and for unmapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_rd | input | 1 | Read strobe; data valid in the same cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| evt_raw | input | 49 | Raw source events, unit u source s at bit (u-1)*7+s |
| tick_pulse | input | 1 | One-second event pulse |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest situation to reach from the ports is a new event landing in exactly the clock cycle that clears its register. This applies both to a source edge during a status read and to a tick pulse during a summary read. The bench reaches it by raising the raw event or the pulse on the same falling edge that asserts the read strobe, so both are sampled by the same rising edge. It then re-reads the register to show that the late event survived while the earlier bits were cleared.

// File: rtl/irq_hub_pkg.sv
`timescale 1ns/1ps
package irq_hub_pkg;
   localparam int NUM_BLK = 8;   // units, bit 0 is the tick
   localparam int MAX_SRC = 7;   // widest unit
   localparam int CNT_W   = 3;   // width of one source-count field
   localparam int DATA_W  = 8;
endpackage

// File: rtl/irq_src_bank.sv
`timescale 1ns/1ps
module irq_src_bank #(
   parameter int N_SRC = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] evt,
   input  logic             en_we,
   input  logic [N_SRC-1:0] en_wdata,
   input  logic             stat_clr,
   output logic [N_SRC-1:0] status,
   output logic [N_SRC-1:0] enable,
   output logic             pending
);
   generate
      if (N_SRC < 1 || N_SRC > 7) begin : g_bad_count
         $error("irq_src_bank: N_SRC must lie in 1..7");
      end
   endgenerate

   logic [N_SRC-1:0] evt_q;
   logic [N_SRC-1:0] rise;

   assign rise = evt & ~evt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q  <= '0;
         status <= '0;
         enable <= '0;
      end else begin
         evt_q  <= evt;
         status <= (stat_clr ? '0 : status) | rise;
         if (en_we) enable <= en_wdata;
      end
   end

   assign pending = |(status & enable);

   // sticky while not read
   assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_clr |=> ((status & $past(status)) == $past(status)));
   // a read with no edge empties the bank
   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr && rise == '0) |=> (status == '0));
   // an edge during the clearing read survives
   assert_keep_on_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr && rise != '0) |=> ((status & $past(rise)) == $past(rise)));
endmodule

// File: rtl/irq_tick_latch.sv
`timescale 1ns/1ps
module irq_tick_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= (flag & ~clr) | pulse;
   end

   assert_tick_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> flag);
   assert_tick_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !pulse) |=> !flag);
endmodule

// File: rtl/irq_hub.sv
`timescale 1ns/1ps
module irq_hub
   import irq_hub_pkg::*;
#(
   parameter int ADDR_W = 8,
   // unit u source count at [(u-1)*CNT_W +: CNT_W], unit 7 in the top field
   parameter logic [(NUM_BLK-1)*CNT_W-1:0] SRC_COUNTS =
      {3'd6, 3'd3, 3'd4, 3'd2, 3'd2, 3'd5, 3'd7},
   parameter logic [ADDR_W-1:0] BLK_EN_ADDR  = 'h04,
   parameter logic [ADDR_W-1:0] SUMMARY_ADDR = 'h05,
   parameter logic [ADDR_W-1:0] STAT_BASE    = 'h10,
   parameter logic [ADDR_W-1:0] EN_BASE      = 'h20
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [ADDR_W-1:0]              bus_addr,
   input  logic                           bus_rd,
   input  logic                           bus_wr,
   input  logic [DATA_W-1:0]              bus_wdata,
   output logic [DATA_W-1:0]              bus_rdata,
   input  logic [(NUM_BLK-1)*MAX_SRC-1:0] evt_raw,
   input  logic                           tick_pulse,
   output logic                           irq_n
);
   generate
      if (ADDR_W < 6) begin : g_bad_addr_w
         $error("irq_hub: ADDR_W too small for the register map");
      end
      if (STAT_BASE == EN_BASE) begin : g_bad_bases
         $error("irq_hub: status and enable bases collide");
      end
   endgenerate

   logic [DATA_W-1:0] summary;
   logic [DATA_W-1:0] blk_en;
   logic [DATA_W-1:0] stat_pad [1:NUM_BLK-1];
   logic [DATA_W-1:0] en_pad   [1:NUM_BLK-1];
   logic              rd_summary;

   assign rd_summary = bus_rd && (bus_addr == SUMMARY_ADDR);

   // upper-level enable register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             blk_en <= '0;
      else if (bus_wr && bus_addr == BLK_EN_ADDR) blk_en <= bus_wdata;
   end

   // bit 0: latched tick
   irq_tick_latch u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .pulse (tick_pulse),
      .clr   (rd_summary),
      .flag  (summary[0])
   );

   // units 1..7: lower-level banks, summary bit derived
   generate
      for (genvar b = 1; b < NUM_BLK; b++) begin : g_unit
         localparam int N = int'(SRC_COUNTS[(b-1)*CNT_W +: CNT_W]);
         logic [N-1:0] st;
         logic [N-1:0] en;
         logic         stat_hit;
         logic         en_hit;

         assign stat_hit = (bus_addr == STAT_BASE + ADDR_W'(b));
         assign en_hit   = (bus_addr == EN_BASE + ADDR_W'(b));

         irq_src_bank #(.N_SRC(N)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (evt_raw[(b-1)*MAX_SRC +: N]),
            .en_we    (bus_wr && en_hit),
            .en_wdata (bus_wdata[N-1:0]),
            .stat_clr (bus_rd && stat_hit),
            .status   (st),
            .enable   (en),
            .pending  (summary[b])
         );

         assign stat_pad[b] = {{(DATA_W-N){1'b0}}, st};
         assign en_pad[b]   = {{(DATA_W-N){1'b0}}, en};

         if (N < MAX_SRC) begin : g_spare
            logic unused_hi;
            assign unused_hi = ^evt_raw[(b-1)*MAX_SRC+N +: MAX_SRC-N];
         end
      end
   endgenerate

   // combinational read port
   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (bus_addr == BLK_EN_ADDR)  bus_rdata = blk_en;
         if (bus_addr == SUMMARY_ADDR) bus_rdata = summary;
         for (int b = 1; b < NUM_BLK; b++) begin
            if (bus_addr == STAT_BASE + ADDR_W'(b)) bus_rdata = stat_pad[b];
            if (bus_addr == EN_BASE + ADDR_W'(b))   bus_rdata = en_pad[b];
         end
      end
   end

   assign irq_n = ~|(summary & blk_en);

   assert_blk_en_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == BLK_EN_ADDR) |=> (blk_en == $past(bus_wdata)));
   assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == '0));
   assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_en == '0) |-> irq_n);
   assert_tick_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_summary && !tick_pulse && !bus_wr && (summary & blk_en) == 8'h01) |=> irq_n);
endmodule

// File: tb/irq_hub_bench.sv
`timescale 1ns/1ps
module irq_hub_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [48:0] evt_raw = '0;
   logic        tick_pulse = 1'b0;
   logic        irq_n;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;   // 125 MHz

   irq_hub u_irq_hub (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_raw(evt_raw), .tick_pulse(tick_pulse), .irq_n(irq_n)
   );

   // {is_read, addr, wdata, expected}
   localparam int NV = 19;
   localparam logic [24:0] VEC [NV] = '{
      {1'b0, 8'h04, 8'hA5, 8'h00}, {1'b1, 8'h04, 8'h00, 8'hA5},
      {1'b0, 8'h21, 8'hFF, 8'h00}, {1'b1, 8'h21, 8'h00, 8'h7F},
      {1'b0, 8'h24, 8'hFF, 8'h00}, {1'b1, 8'h24, 8'h00, 8'h03},
      {1'b0, 8'h26, 8'hFF, 8'h00}, {1'b1, 8'h26, 8'h00, 8'h07},
      {1'b0, 8'h27, 8'hFF, 8'h00}, {1'b1, 8'h27, 8'h00, 8'h3F},
      {1'b0, 8'h05, 8'hFF, 8'h00}, {1'b1, 8'h05, 8'h00, 8'h00},
      {1'b1, 8'h33, 8'h00, 8'h00},
      {1'b0, 8'h04, 8'h00, 8'h00}, {1'b1, 8'h04, 8'h00, 8'h00},
      {1'b0, 8'h21, 8'h00, 8'h00}, {1'b0, 8'h24, 8'h00, 8'h00},
      {1'b0, 8'h26, 8'h00, 8'h00}, {1'b0, 8'h27, 8'h00, 8'h00}
   };

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0; #1;
   endtask

   task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1;
      chk(tag, bus_rdata, exp);
      @(negedge clk); bus_rd = 1'b0; #1;
   endtask

   task automatic pulse_evt(input int idx);
      @(negedge clk); evt_raw[idx] = 1'b1;
      @(negedge clk); evt_raw[idx] = 1'b0; #1;
   endtask

   task automatic summary_line;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary_line();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
      rd(8'h04, 8'h00, "R1 unit enable");
      rd(8'h05, 8'h00, "R1 summary");
      rd(8'h12, 8'h00, "R1 source status");
      rd(8'h22, 8'h00, "R1 source enable");

      // register table: R2 R5 R8 R11
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][24]) begin
            if (VEC[i][23:16] == 8'h04)      rd(VEC[i][23:16], VEC[i][7:0], "R2 table");
            else if (VEC[i][23:16] == 8'h05) rd(VEC[i][23:16], VEC[i][7:0], "R8 table");
            else if (VEC[i][23:16] == 8'h33) rd(VEC[i][23:16], VEC[i][7:0], "R11 table");
            else                             rd(VEC[i][23:16], VEC[i][7:0], "R5 table");
         end else begin
            wr(VEC[i][23:16], VEC[i][15:8]);
         end
      end

      // R3: unit 2 source 3 = raw bit 10, held high
      @(negedge clk); evt_raw[10] = 1'b1;
      rd(8'h12, 8'h08, "R3 latch");
      rd(8'h12, 8'h00, "R3 held level no relatch");
      @(negedge clk); evt_raw[10] = 1'b0;

      // R6 / R9 masking at both levels
      pulse_evt(10);
      rd(8'h05, 8'h00, "R6 source-masked");
      wr(8'h22, 8'h08);
      rd(8'h05, 8'h04, "R6 summary bit 2");
      chk("R9 unit disabled", {7'd0, irq_n}, 8'h01);
      wr(8'h04, 8'h04);
      chk("R9 asserted", {7'd0, irq_n}, 8'h00);
      wr(8'h22, 8'h00);
      chk("R6 source enable off", {7'd0, irq_n}, 8'h01);
      wr(8'h22, 8'h08);
      chk("R9 reasserted", {7'd0, irq_n}, 8'h00);

      // R10: clearing read releases irq_n on next cycle
      @(negedge clk); bus_rd = 1'b1; bus_addr = 8'h12; #1;
      chk("R10 read data", bus_rdata, 8'h08);
      chk("R10 still low in read cycle", {7'd0, irq_n}, 8'h00);
      @(negedge clk); bus_rd = 1'b0; #1;
      chk("R10 released", {7'd0, irq_n}, 8'h01);

      // R4: edge coincides with clearing read
      pulse_evt(9);
      @(negedge clk); bus_rd = 1'b1; bus_addr = 8'h12; evt_raw[10] = 1'b1; #1;
      chk("R4 read old", bus_rdata, 8'h04);
      @(negedge clk); bus_rd = 1'b0; evt_raw[10] = 1'b0; #1;
      chk("R4 irq kept", {7'd0, irq_n}, 8'h00);
      rd(8'h12, 8'h08, "R4 late edge kept");
      chk("R4 cleared", {7'd0, irq_n}, 8'h01);

      // R7 tick
      wr(8'h04, 8'h00);
      @(negedge clk); tick_pulse = 1'b1;
      @(negedge clk); tick_pulse = 1'b0;
      rd(8'h05, 8'h01, "R7 tick set");
      rd(8'h05, 8'h00, "R7 tick cleared");
      @(negedge clk); tick_pulse = 1'b1;
      @(negedge clk); tick_pulse = 1'b0;
      wr(8'h04, 8'h01);
      chk("R9 tick irq", {7'd0, irq_n}, 8'h00);
      wr(8'h05, 8'h00);
      chk("R8 summary write ignored", {7'd0, irq_n}, 8'h00);
      @(negedge clk); bus_rd = 1'b1; bus_addr = 8'h05; tick_pulse = 1'b1; #1;
      chk("R7 coincident read", bus_rdata, 8'h01);
      @(negedge clk); bus_rd = 1'b0; tick_pulse = 1'b0; #1;
      chk("R7 coincident kept", {7'd0, irq_n}, 8'h00);
      rd(8'h05, 8'h01, "R7 tick after coincident");
      chk("R10 tick released", {7'd0, irq_n}, 8'h01);

      // R8 write to source status
      pulse_evt(10);
      wr(8'h12, 8'h00);
      rd(8'h12, 8'h08, "R8 status write ignored");

      // R6 top bit order: unit 7 source 0 = raw bit 42
      wr(8'h27, 8'h01);
      wr(8'h04, 8'h80);
      pulse_evt(42);
      chk("R9 unit 7 irq", {7'd0, irq_n}, 8'h00);
      rd(8'h05, 8'h80, "R6 summary bit 7");
      rd(8'h17, 8'h01, "R3 unit 7 status");
      chk("R10 unit 7 released", {7'd0, irq_n}, 8'h01);

      // R11 idle bus
      @(negedge clk); bus_addr = 8'h04; #1;
      chk("R11 idle rdata", bus_rdata, 8'h00);

      summary_line();
      $finish;
   end
endmodule